// File: doc/BRIEF.md
# Variable-Length Synchronous Serial Transceiver

This block moves short frames over a clocked serial link. Each frame is from one to eight bits long. A byte written to the transmit holding buffer is copied into a shift register once transmission is enabled and the shifter is idle. It then goes out on `sdo`, one bit per serial clock period. In the same clock periods the bits on `sdi` are gathered into a receive word. Reception is therefore always paced by a transmission. A frame received while reception is enabled is copied into a receive buffer, and that copy raises a receive interrupt pulse.

The serial clock comes from one of two places. The block can generate it from the system clock, with a 16-bit divisor setting the period. It can also follow an external clock input after synchronising it. Data changes on a falling edge and is sampled on the rising edge. The clock rests high between frames.

Per-frame options are length, bit order, and inversion of both data lines. The transmit interrupt is raised either when the buffer is copied into the shifter or when the frame has finished. An overrun flag marks a frame that completed while the previous one was still unread.

Top module: `sersync_xcvr`

## Requirements
- R1: After reset, `sclk_out` and `sdo` are 1, `tx_irq`, `rx_irq` and `overrun` are 0, and `rx_data` is 0.
- R2: With `frame_len` = L (0..7), a frame has exactly L+1 bits and therefore exactly L+1 rising serial clock edges.
- R3: With `ext_clk_sel` = 0, `sclk_out` has a period of 2·(`divisor`+2) system clock cycles while a frame runs, and it is high whenever the block is idle. `sdo` changes only as `sclk_out` falls.
- R4: With `ext_clk_sel` = 1, `sclk_out` stays high. Bits are driven on falling edges of `sclk_in` and sampled on its rising edges.
- R5: A frame starts only when `tx_en` is 1 and the transmit buffer holds data. Data written while `tx_en` is 0 waits, with no clock activity, until `tx_en` is set.
- R6: With `msb_first` = 0, bit 0 of `tx_data` goes first, then ascending bit numbers. With `msb_first` = 1, bit 7 goes first, then descending bit numbers. The k-th received bit is stored at the same position as the k-th transmitted bit, and positions beyond the frame length read 0.
- R7: With `invert` = 1, the level on `sdo` is the complement of the data bit, and a received bit is the complement of the level on `sdi`.
- R8: With `txirq_on_done` = 0, `tx_irq` pulses when the buffer is copied into the shifter, before the first serial clock fall. With `txirq_on_done` = 1, it pulses only after the last rising edge of the frame.
- R9: If `rx_en` was 1 when the frame started, the frame's end updates `rx_data` and pulses `rx_irq`. If `rx_en` was 0, neither happens and `rx_data` keeps its value.
- R10: A received frame sets `overrun` if the previous received word was not read with `rx_rd`, and clears `overrun` if it was. Otherwise `overrun` holds until a pulse on `ovr_clr`.
- R11: `tx_irq` and `rx_irq` are single-cycle pulses, one for each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| msb_first | input | 1 | 1: bit 7 first; 0: bit 0 first |
| invert | input | 1 | Invert the data-out and data-in levels |
| frame_len | input | 3 | Frame length minus one |
| ext_clk_sel | input | 1 | 1: follow `sclk_in`; 0: internal divider |
| txirq_on_done | input | 1 | Transmit interrupt source: 1 frame end, 0 buffer load |
| divisor | input | 16 | Internal clock divisor n; period 2(n+2) |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| ovr_clr | input | 1 | Write-one pulse that clears `overrun` |
| rx_data | output | 8 | Receive buffer |
| sclk_in | input | 1 | External serial clock |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated serial clock, idles high |
| sdo | output | 1 | Serial data out |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Overrun flag |

## Verification
A bit index that is off by one shows at once, within the frame in which it occurs: the number of rising serial clock edges is wrong, and the captured `sdo` pattern is shifted or reversed. A wrong divider count appears at the second rising edge as a period mismatch. A stale receive-full bit only shows one frame later, when `overrun` takes the wrong value. The bench therefore compares the flag after every frame, against a model that tracks reads. A wrong interrupt source shows as the number of clock edges already seen when `tx_irq` pulses.

// File: rtl/sersync_pkg.sv
package sersync_pkg;

    localparam int SER_DATA_W = 8;
    localparam int SER_IDX_W  = $clog2(SER_DATA_W);

    typedef logic [SER_DATA_W-1:0] ser_word_t;
    typedef logic [SER_IDX_W-1:0]  ser_idx_t;

    // Options frozen when a word enters the shifter
    typedef struct packed {
        ser_idx_t len_m1;
        logic     msb_first;
        logic     invert;
        logic     rx_on;
    } frame_cfg_t;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } sh_state_e;

    // Bit position on the wire for the idx-th bit of a frame
    function automatic ser_idx_t wire_pos(input logic msb_first, input ser_idx_t idx);
        ser_idx_t p;
        if (msb_first)
            p = ser_idx_t'(SER_DATA_W - 1) - idx;
        else
            p = idx;
        return p;
    endfunction

endpackage

// File: rtl/sersync_clkgen.sv
module sersync_clkgen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             fall_ev,
    output logic             rise_ev
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0]       half_cnt;
    logic [CNT_W-1:0]       half_lim;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev;
    logic                   tick;
    logic                   ext_lvl;

    // half period lasts divisor+2 system cycles
    assign half_lim = CNT_W'(divisor) + CNT_W'(1);
    assign tick     = run && !ext_sel && (half_cnt == half_lim);
    assign ext_lvl  = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            ext_prev <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], sclk_in};
            ext_prev <= ext_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || ext_sel) begin
            half_cnt <= '0;
            sclk_out <= 1'b1;
        end else if (tick) begin
            half_cnt <= '0;
            sclk_out <= ~sclk_out;
        end else begin
            half_cnt <= half_cnt + CNT_W'(1);
        end
    end

    always_comb begin
        if (ext_sel) begin
            fall_ev = run && ext_prev && !ext_lvl;
            rise_ev = run && !ext_prev && ext_lvl;
        end else begin
            fall_ev = tick && sclk_out;
            rise_ev = tick && !sclk_out;
        end
    end

endmodule

// File: rtl/sersync_shifter.sv
module sersync_shifter
    import sersync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_cfg_t cfg_in,
    input  ser_word_t  tx_word,
    input  logic       fall_ev,
    input  logic       rise_ev,
    input  logic       sdi,
    output logic       active,
    output logic       sdo,
    output logic       frame_done,
    output logic       capture,
    output ser_word_t  rx_word
);
    sh_state_e  state;
    frame_cfg_t cfg_q;
    ser_idx_t   bit_idx;
    ser_idx_t   pos;
    ser_word_t  tx_q;
    ser_word_t  rx_acc;
    ser_word_t  rx_next;
    logic       last_bit;

    assign active   = (state == SH_SHIFT);
    assign pos      = wire_pos(cfg_q.msb_first, bit_idx);
    assign last_bit = (bit_idx == cfg_q.len_m1);

    always_comb begin
        rx_next      = rx_acc;
        rx_next[pos] = sdi ^ cfg_q.invert;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SH_IDLE;
            cfg_q      <= '0;
            bit_idx    <= '0;
            tx_q       <= '0;
            rx_acc     <= '0;
            rx_word    <= '0;
            sdo        <= 1'b1;
            frame_done <= 1'b0;
            capture    <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            capture    <= 1'b0;
            if (start) begin
                state   <= SH_SHIFT;
                cfg_q   <= cfg_in;
                bit_idx <= '0;
                tx_q    <= tx_word;
                rx_acc  <= '0;
            end else if (state == SH_SHIFT) begin
                if (fall_ev)
                    sdo <= tx_q[pos] ^ cfg_q.invert;
                if (rise_ev) begin
                    rx_acc <= rx_next;
                    if (last_bit) begin
                        state      <= SH_IDLE;
                        frame_done <= 1'b1;
                        capture    <= cfg_q.rx_on;
                        rx_word    <= rx_next;
                    end else begin
                        bit_idx <= bit_idx + ser_idx_t'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sersync_txbuf.sv
module sersync_txbuf
    import sersync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  ser_word_t wdata,
    input  logic      load,
    input  logic      frame_done,
    input  logic      irq_on_done,
    output logic      full,
    output ser_word_t data,
    output logic      tx_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data   <= '0;
            tx_irq <= 1'b0;
        end else begin
            if (wr) begin
                full <= 1'b1;
                data <= wdata;
            end else if (load) begin
                full <= 1'b0;
            end
            tx_irq <= irq_on_done ? frame_done : load;
        end
    end

endmodule

// File: rtl/sersync_rxbuf.sv
module sersync_rxbuf
    import sersync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  ser_word_t word,
    input  logic      rd,
    input  logic      ovr_clr,
    output ser_word_t data,
    output logic      rx_irq,
    output logic      overrun
);
    logic full;

    always_ff @(posedge clk) begin
        if (rst) begin
            data    <= '0;
            full    <= 1'b0;
            rx_irq  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            rx_irq <= capture;
            if (capture) begin
                data    <= word;
                full    <= 1'b1;
                overrun <= full && !rd;
            end else begin
                if (rd)
                    full <= 1'b0;
                if (ovr_clr)
                    overrun <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sersync_xcvr.sv
module sersync_xcvr
    import sersync_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_en,
    input  logic                  rx_en,
    input  logic                  msb_first,
    input  logic                  invert,
    input  logic [SER_IDX_W-1:0]  frame_len,
    input  logic                  ext_clk_sel,
    input  logic                  txirq_on_done,
    input  logic [DIV_W-1:0]      divisor,
    input  logic                  tx_wr,
    input  logic [SER_DATA_W-1:0] tx_data,
    input  logic                  rx_rd,
    input  logic                  ovr_clr,
    output logic [SER_DATA_W-1:0] rx_data,
    input  logic                  sclk_in,
    input  logic                  sdi,
    output logic                  sclk_out,
    output logic                  sdo,
    output logic                  tx_irq,
    output logic                  rx_irq,
    output logic                  overrun
);
    frame_cfg_t cfg_now;
    ser_word_t  tx_hold;
    ser_word_t  rx_word;
    logic       tx_full;
    logic       sh_active;
    logic       start;
    logic       fall_ev;
    logic       rise_ev;
    logic       frame_done;
    logic       capture;

    assign cfg_now = '{len_m1: frame_len, msb_first: msb_first,
                       invert: invert, rx_on: rx_en};
    assign start   = !sh_active && tx_en && tx_full;

    sersync_clkgen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (sh_active),
        .ext_sel (ext_clk_sel),
        .divisor (divisor),
        .sclk_in (sclk_in),
        .sclk_out(sclk_out),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    sersync_txbuf u_tx (
        .clk        (clk),
        .rst        (rst),
        .wr         (tx_wr),
        .wdata      (tx_data),
        .load       (start),
        .frame_done (frame_done),
        .irq_on_done(txirq_on_done),
        .full       (tx_full),
        .data       (tx_hold),
        .tx_irq     (tx_irq)
    );

    sersync_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg_now),
        .tx_word   (tx_hold),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .sdi       (sdi),
        .active    (sh_active),
        .sdo       (sdo),
        .frame_done(frame_done),
        .capture   (capture),
        .rx_word   (rx_word)
    );

    sersync_rxbuf u_rx (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .word   (rx_word),
        .rd     (rx_rd),
        .ovr_clr(ovr_clr),
        .data   (rx_data),
        .rx_irq (rx_irq),
        .overrun(overrun)
    );

endmodule

// File: rtl/sersync_xcvr_chk.sv
module sersync_xcvr_chk
    import sersync_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ext_clk_sel,
    input logic            active,
    input logic            sclk_out,
    input logic            sdo,
    input logic            tx_irq,
    input logic            rx_irq,
    input logic            overrun,
    input logic [SER_DATA_W-1:0] rx_data
);
    // R3
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> sclk_out);

    // R3
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_clk_sel && !$stable(sdo)) |-> $fell(sclk_out));

    // R4
    ext_clk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_clk_sel && $past(ext_clk_sel)) |-> sclk_out);

    // R11
    tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    // R11
    rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    // R9
    rx_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_irq);

    // R10
    ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> rx_irq);

endmodule

bind sersync_xcvr sersync_xcvr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_clk_sel(ext_clk_sel),
    .active     (sh_active),
    .sclk_out   (sclk_out),
    .sdo        (sdo),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq),
    .overrun    (overrun),
    .rx_data    (rx_data)
);

// File: tb/sim_sersync_xcvr.sv
module sim_sersync_xcvr;
    import sersync_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0, rx_en = 1'b0, msb_first = 1'b0, invert = 1'b0;
    logic [2:0]  frame_len = 3'd0;
    logic        ext_clk_sel = 1'b0, txirq_on_done = 1'b0;
    logic [15:0] divisor = 16'd0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
    logic [7:0]  tx_data = 8'd0;
    logic [7:0]  rx_data;
    logic        sclk_in = 1'b1, sdi = 1'b0;
    logic        sclk_out, sdo, tx_irq, rx_irq, overrun;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    sersync_xcvr u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
        .msb_first(msb_first), .invert(invert), .frame_len(frame_len),
        .ext_clk_sel(ext_clk_sel), .txirq_on_done(txirq_on_done),
        .divisor(divisor), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .ovr_clr(ovr_clr), .rx_data(rx_data),
        .sclk_in(sclk_in), .sdi(sdi), .sclk_out(sclk_out), .sdo(sdo),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    // line-side partner: captures sdo on rising edges, drives sdi on falling edges
    wire line_clk = ext_clk_sel ? sclk_in : sclk_out;
    int         rises = 0, falls = 0, last_rise = 0, period = 0;
    logic [7:0] cap = 8'd0;
    logic [7:0] drv = 8'd0;
    always @(posedge line_clk) begin
        if (rises < 8) cap[rises[2:0]] = sdo;
        if (rises > 0) period = cyc - last_rise;
        last_rise = cyc;
        rises++;
    end
    always @(negedge line_clk) begin
        sdi = drv[falls[2:0]];
        falls++;
    end

    int   txirq_cnt = 0, rxirq_cnt = 0, txirq_rises = 0, txirq_falls = 0;
    logic sclk_low_seen = 1'b0;
    always @(negedge clk) begin
        if (tx_irq) begin txirq_cnt++; txirq_rises = rises; txirq_falls = falls; end
        if (rx_irq) rxirq_cnt++;
        if (!sclk_out) sclk_low_seen = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pos_of(input bit msb, input int k);
        return msb ? 7 - k : k;
    endfunction

    function automatic logic [7:0] exp_line(input logic [7:0] d, input int len,
                                            input bit msb, input bit inv);
        logic [7:0] v = 8'd0;
        for (int k = 0; k < len; k++) v[k] = d[pos_of(msb, k)] ^ inv;
        return v;
    endfunction

    function automatic logic [7:0] exp_rx(input logic [7:0] line, input int len,
                                          input bit msb, input bit inv);
        logic [7:0] v = 8'd0;
        for (int k = 0; k < len; k++) v[pos_of(msb, k)] = line[k] ^ inv;
        return v;
    endfunction

    // bench model of the receive buffer and overrun flag
    bit m_full = 1'b0;
    bit m_ovr  = 1'b0;

    task automatic frame(input logic [7:0] d, input int len, input bit msb,
                         input bit inv, input bit ext, input int div,
                         input bit rxen, input bit sel, input logic [7:0] pat,
                         input bit hold, input bit do_rd, input bit do_clr);
        logic [7:0] prev_rx;
        logic [7:0] line_mask;
        @(negedge clk);
        frame_len = 3'(len - 1); msb_first = msb; invert = inv;
        ext_clk_sel = ext; divisor = 16'(div); rx_en = rxen; txirq_on_done = sel;
        drv = pat; tx_en = !hold;
        @(negedge clk);
        rises = 0; falls = 0; cap = 8'd0; period = 0;
        txirq_cnt = 0; rxirq_cnt = 0; txirq_rises = -1; txirq_falls = -1;
        sclk_low_seen = 1'b0; prev_rx = rx_data;
        tx_data = d; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        if (hold) begin
            repeat (40) @(negedge clk);
            // R5: nothing moves while transmit is disabled
            chk(rises == 0 && sclk_out && txirq_cnt == 0, "R5", "held start",
                rises, 0);
            tx_en = 1'b1;
        end
        if (ext) begin
            repeat (4) @(negedge clk);
            for (int k = 0; k < len; k++) begin
                sclk_in = 1'b0; repeat (10) @(negedge clk);
                sclk_in = 1'b1; repeat (10) @(negedge clk);
            end
            repeat (8) @(negedge clk);
            // R4: generated clock stays idle in external mode
            chk(!sclk_low_seen, "R4", "sclk_out low in ext mode", sclk_low_seen, 0);
        end else begin
            while (rises < len) @(negedge clk);
            repeat (6) @(negedge clk);
            if (len >= 2)
                // R3: clock period from the divisor
                chk(period == 2 * (div + 2), "R3", "sclk period", period, 2 * (div + 2));
            chk(sclk_out == 1'b1, "R3", "sclk idle level", sclk_out, 1);
        end
        // R2: number of bit clocks
        chk(rises == len, "R2", "rising edges", rises, len);
        line_mask = 8'((1 << len) - 1);
        // R6 / R7: order and polarity of transmitted bits
        chk((cap & line_mask) == exp_line(d, len, msb, inv), "R6", "sdo bits",
            int'(cap & line_mask), int'(exp_line(d, len, msb, inv)));
        // R8 / R11: transmit interrupt source and single pulse
        if (sel)
            chk(txirq_cnt == 1 && txirq_rises == len, "R8", "tx_irq on done",
                txirq_rises, len);
        else
            chk(txirq_cnt == 1 && txirq_rises == 0 && txirq_falls == 0, "R8",
                "tx_irq on load", txirq_rises, 0);
        chk(txirq_cnt == 1, "R11", "tx_irq pulse count", txirq_cnt, 1);
        // R9 / R11: receive path
        if (rxen) begin
            chk(rxirq_cnt == 1, "R11", "rx_irq pulse count", rxirq_cnt, 1);
            chk(rx_data == exp_rx(pat, len, msb, inv), "R9", "rx_data",
                rx_data, int'(exp_rx(pat, len, msb, inv)));
            m_ovr  = m_full;
            m_full = 1'b1;
        end else begin
            chk(rxirq_cnt == 0 && rx_data == prev_rx, "R9", "rx disabled",
                rx_data, prev_rx);
        end
        // R10: overrun after the frame
        chk(overrun == m_ovr, "R10", "overrun after frame", overrun, m_ovr);
        if (do_rd) begin
            rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
            m_full = 1'b0;
        end
        if (do_clr) begin
            ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
            m_ovr = 1'b0;
            @(negedge clk);
            chk(overrun == 1'b0, "R10", "overrun cleared", overrun, 0);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int unsigned s;
        s = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(sclk_out && sdo && !tx_irq && !rx_irq && !overrun && rx_data == 8'd0,
            "R1", "reset state", {sclk_out, sdo, tx_irq, rx_irq, overrun}, 5'b11000);

        // directed corners
        frame(8'hA5, 1, 0, 0, 0, 0, 1, 0, 8'h01, 0, 1, 0);   // single bit, fastest clock
        frame(8'h3C, 8, 1, 1, 0, 1, 1, 1, 8'hB2, 0, 1, 0);   // MSB first, inverted
        frame(8'hC3, 2, 0, 0, 0, 300, 1, 1, 8'h02, 0, 1, 0); // large divisor
        frame(8'h5A, 5, 0, 0, 0, 2, 1, 0, 8'h15, 1, 0, 0);   // R5 held start
        frame(8'h96, 6, 1, 0, 1, 0, 1, 1, 8'h2D, 0, 0, 0);   // external clock, no read
        frame(8'h0F, 4, 0, 1, 0, 1, 1, 0, 8'h09, 0, 0, 0);   // R10 overrun set
        frame(8'hF0, 3, 1, 0, 0, 0, 1, 1, 8'h05, 0, 0, 1);   // R10 stays set, then W1C
        frame(8'h77, 7, 0, 0, 0, 3, 0, 0, 8'h55, 0, 0, 0);   // R9 receive disabled
        frame(8'h11, 3, 0, 0, 0, 0, 1, 0, 8'h06, 0, 1, 0);   // R10 unread -> overrun
        frame(8'h22, 3, 0, 0, 0, 0, 1, 0, 8'h03, 0, 1, 0);   // R10 read -> overrun clears

        // constrained random frames
        for (int i = 0; i < 40; i++) begin
            frame(8'($urandom), int'($urandom_range(1, 8)), 1'($urandom),
                  1'($urandom), ($urandom_range(0, 3) == 0),
                  int'($urandom_range(0, 6)), ($urandom_range(0, 7) != 0),
                  1'($urandom), 8'($urandom), ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 2) != 0), ($urandom_range(0, 4) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule